// File: doc/BRIEF.md
# Redundant-Coded Windowed Watchdog

This block supervises a host processor. It counts ticks of an always-running oscillator and not cycles of the host clock. The host services it by presenting a service access that carries two fields. One is a 4-bit period selector and the other is a 3-bit operating-mode selector. Both fields are redundantly coded, so only a sparse subset of their bit patterns is accepted. A corrupted access never just restarts the timer. It raises an immediate reset request that carries a cause code.

The block has four supervision behaviours. Start-up gives software a fixed initial period to come up. Window rejects service that comes too early and also service that comes too late. Time-out rejects only late service. In time-out behaviour the first expiry gives a wake-up interrupt instead of a reset, which makes it usable as a cyclic wake-up source. Off does no supervision. After every reset request the block falls back to start-up behaviour with its start period, ready for the restarted software.

The transport of the service access and the sequencing of the chip's operating modes are handled elsewhere. The block only sees a one-cycle `svc_valid` strobe with the two code fields.

Top module: `redund_wdog`

## Requirements
- R1: After reset the block is in start-up behaviour with period index START_IDX. With no service, the tick that completes that period produces a reset request with cause 2'b01 (overflow).
- R2: A period code is legal exactly when it has one or two bits set, which gives ten codes. Legal codes are ranked by ascending binary value as index n = 0..9, and index n selects a period of 2^(n+BASE_LOG2) ticks.
- R3: A service access with an illegal period code produces a reset request with cause 2'b10 (bad period) on the next cycle. This check takes precedence over every other check on the same access.
- R4: Mode codes 3'b000 and 3'b111 are illegal. A service access with a legal period and an illegal mode produces a reset request with cause 2'b11 (bad mode).
- R5: Legal mode codes select the behaviour as follows: 3'b001 start-up, 3'b010 window, 3'b011 and 3'b100 time-out, 3'b101 and 3'b110 off.
- R6: In window behaviour, service while fewer than half the period's ticks have elapsed since the last restart produces a reset request with cause 2'b00 (early).
- R7: In window behaviour, service in the second half of the period is accepted without any output. If the period expires unserviced, a reset request with cause 2'b01 follows.
- R8: In time-out behaviour, the first unserviced expiry gives a one-cycle wake_irq pulse and starts a new period. A second consecutive expiry gives a reset request with cause 2'b01.
- R9: In off behaviour, oscillator ticks have no effect and no output is ever raised.
- R10: An accepted service loads the new period and behaviour and clears the elapsed count. An oscillator tick in the same cycle as a service is not counted.
- R11: After any reset request, the block returns to start-up behaviour with period index START_IDX and a cleared count.
- R12: rst_req and wake_irq are registered single-cycle pulses in the cycle after the triggering edge. rst_cause reads 2'b00 whenever rst_req is low, and the two pulses are never high together.
- R13: In start-up and time-out behaviour, service is accepted at any point in the period and never counts as early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator tick |
| svc_valid | input | 1 | Service access strobe |
| svc_period | input | 4 | Redundant period code |
| svc_mode | input | 3 | Redundant operating-mode code |
| rst_req | output | 1 | Reset request pulse |
| rst_cause | output | 2 | Cause: 00 early, 01 overflow, 10 bad period, 11 bad mode |
| wake_irq | output | 1 | Cyclic wake-up interrupt pulse |

## Verification
The bench builds the block with BASE_LOG2 = 2 and START_IDX = 3. The ten periods then run from 4 to 2048 ticks, and the start period is 32 ticks. With these values every legal period code can be driven to overflow in window behaviour, and the time-out double expiry can be reached quickly. The early and late boundaries at the half-period point can also be probed on both sides. Illegal codes, including a doubly corrupted access, are mixed with ticks that arrive on some cycles and not others and with ticks that coincide with service. A behavioural model predicts every output on every cycle.

// File: rtl/redund_wdog_pkg.sv
package redund_wdog_pkg;

    localparam int PCODE_W     = 4;
    localparam int MCODE_W     = 3;
    localparam int NUM_PERIODS = 10;
    localparam int IDX_W       = 4;

    typedef enum logic [1:0] {
        BEH_START   = 2'd0,
        BEH_WINDOW  = 2'd1,
        BEH_TIMEOUT = 2'd2,
        BEH_OFF     = 2'd3
    } wd_behav_e;

    typedef enum logic [1:0] {
        CAUSE_EARLY      = 2'b00,
        CAUSE_OVERFLOW   = 2'b01,
        CAUSE_BAD_PERIOD = 2'b10,
        CAUSE_BAD_MODE   = 2'b11
    } wd_cause_e;

    localparam logic [MCODE_W-1:0] MC_BOOT    = 3'b001;
    localparam logic [MCODE_W-1:0] MC_RUN     = 3'b010;
    localparam logic [MCODE_W-1:0] MC_IDLE    = 3'b011;
    localparam logic [MCODE_W-1:0] MC_UPDATE  = 3'b100;
    localparam logic [MCODE_W-1:0] MC_DORMANT = 3'b101;
    localparam logic [MCODE_W-1:0] MC_HALT    = 3'b110;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } period_dec_t;

    typedef struct packed {
        logic      valid;
        wd_behav_e behav;
    } mode_dec_t;

    // A period code is legal with exactly one or two bits set.
    function automatic logic period_code_legal(input logic [PCODE_W-1:0] code);
        int ones;
        ones = $countones(code);
        return (ones == 1) || (ones == 2);
    endfunction

    // Rank of a legal code among legal codes of lower binary value.
    function automatic logic [IDX_W-1:0] period_code_index(input logic [PCODE_W-1:0] code);
        logic [IDX_W-1:0] n;
        n = '0;
        for (int v = 0; v < (1 << PCODE_W); v++) begin
            if ((v < int'(code)) && period_code_legal(PCODE_W'(v)))
                n = n + 4'd1;
        end
        return n;
    endfunction

    function automatic logic mode_code_legal(input logic [MCODE_W-1:0] code);
        return (code != 3'b000) && (code != 3'b111);
    endfunction

    function automatic wd_behav_e mode_behaviour(input logic [MCODE_W-1:0] code);
        wd_behav_e b;
        case (code)
            MC_BOOT:              b = BEH_START;
            MC_RUN:               b = BEH_WINDOW;
            MC_IDLE, MC_UPDATE:   b = BEH_TIMEOUT;
            MC_DORMANT, MC_HALT:  b = BEH_OFF;
            default:              b = BEH_START;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/wdog_code_check.sv
module wdog_code_check
    import redund_wdog_pkg::*;
(
    input  logic [PCODE_W-1:0] period_code,
    input  logic [MCODE_W-1:0] mode_code,
    output period_dec_t        pdec,
    output mode_dec_t          mdec
);

    always_comb begin
        pdec.valid = period_code_legal(period_code);
        pdec.idx   = pdec.valid ? period_code_index(period_code) : '0;
        mdec.valid = mode_code_legal(mode_code);
        mdec.behav = mode_behaviour(mode_code);
    end

endmodule

// File: rtl/wdog_period_lut.sv
module wdog_period_lut
    import redund_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 4,
    parameter int CNT_W     = BASE_LOG2 + NUM_PERIODS
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] per_last,
    output logic [CNT_W-1:0] per_half
);

    logic [CNT_W-1:0] tab [NUM_PERIODS];

    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_tab
        assign tab[g] = CNT_W'(1) << (g + BASE_LOG2);
    end

    logic [CNT_W-1:0] sel;

    always_comb begin
        sel = tab[0];
        for (int i = 0; i < NUM_PERIODS; i++) begin
            if (idx == IDX_W'(i)) sel = tab[i];
        end
        per_last = sel - CNT_W'(1);
        per_half = sel >> 1;
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import redund_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 4,
    parameter int START_IDX = 7,
    parameter int CNT_W     = BASE_LOG2 + NUM_PERIODS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             svc_valid,
    input  period_dec_t      pdec,
    input  mode_dec_t        mdec,
    input  logic [CNT_W-1:0] per_last,
    input  logic [CNT_W-1:0] per_half,
    output logic [IDX_W-1:0] cur_idx,
    output logic             rst_req,
    output wd_cause_e        rst_cause,
    output logic             wake_irq
);

    localparam logic [IDX_W-1:0] START_I = IDX_W'(START_IDX);

    wd_behav_e        behav_q, behav_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;
    logic [IDX_W-1:0] idx_q,   idx_d;
    logic             sent_q,  sent_d;
    logic             req_d,   irq_d;
    wd_cause_e        cause_d;
    logic             restart;
    logic             early;
    logic             expire;

    assign early  = (behav_q == BEH_WINDOW) && (cnt_q < per_half);
    assign expire = (cnt_q == per_last);

    always_comb begin
        behav_d = behav_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sent_d  = sent_q;
        req_d   = 1'b0;
        irq_d   = 1'b0;
        cause_d = CAUSE_EARLY;
        restart = 1'b0;
        if (svc_valid) begin
            if (!pdec.valid) begin
                req_d   = 1'b1;
                cause_d = CAUSE_BAD_PERIOD;
                restart = 1'b1;
            end else if (!mdec.valid) begin
                req_d   = 1'b1;
                cause_d = CAUSE_BAD_MODE;
                restart = 1'b1;
            end else if (early) begin
                req_d   = 1'b1;
                cause_d = CAUSE_EARLY;
                restart = 1'b1;
            end else begin
                behav_d = mdec.behav;
                idx_d   = pdec.idx;
                cnt_d   = '0;
                sent_d  = 1'b0;
            end
        end else if (osc_tick && (behav_q != BEH_OFF)) begin
            if (expire) begin
                if ((behav_q == BEH_TIMEOUT) && !sent_q) begin
                    irq_d  = 1'b1;
                    sent_d = 1'b1;
                    cnt_d  = '0;
                end else begin
                    req_d   = 1'b1;
                    cause_d = CAUSE_OVERFLOW;
                    restart = 1'b1;
                end
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
        if (restart) begin
            behav_d = BEH_START;
            idx_d   = START_I;
            cnt_d   = '0;
            sent_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            behav_q   <= BEH_START;
            cnt_q     <= '0;
            idx_q     <= START_I;
            sent_q    <= 1'b0;
            rst_req   <= 1'b0;
            rst_cause <= CAUSE_EARLY;
            wake_irq  <= 1'b0;
        end else begin
            behav_q   <= behav_d;
            cnt_q     <= cnt_d;
            idx_q     <= idx_d;
            sent_q    <= sent_d;
            rst_req   <= req_d;
            rst_cause <= cause_d;
            wake_irq  <= irq_d;
        end
    end

    assign cur_idx = idx_q;

endmodule

// File: rtl/redund_wdog.sv
module redund_wdog
    import redund_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 4,
    parameter int START_IDX = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               osc_tick,
    input  logic               svc_valid,
    input  logic [PCODE_W-1:0] svc_period,
    input  logic [MCODE_W-1:0] svc_mode,
    output logic               rst_req,
    output logic [1:0]         rst_cause,
    output logic               wake_irq
);

    localparam int CNT_W = BASE_LOG2 + NUM_PERIODS;

    period_dec_t      pdec;
    mode_dec_t        mdec;
    logic [IDX_W-1:0] cur_idx;
    logic [CNT_W-1:0] per_last;
    logic [CNT_W-1:0] per_half;
    wd_cause_e        cause_e;

    wdog_code_check u_check (
        .period_code (svc_period),
        .mode_code   (svc_mode),
        .pdec        (pdec),
        .mdec        (mdec)
    );

    wdog_period_lut #(
        .BASE_LOG2 (BASE_LOG2),
        .CNT_W     (CNT_W)
    ) u_lut (
        .idx      (cur_idx),
        .per_last (per_last),
        .per_half (per_half)
    );

    wdog_core #(
        .BASE_LOG2 (BASE_LOG2),
        .START_IDX (START_IDX),
        .CNT_W     (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .svc_valid (svc_valid),
        .pdec      (pdec),
        .mdec      (mdec),
        .per_last  (per_last),
        .per_half  (per_half),
        .cur_idx   (cur_idx),
        .rst_req   (rst_req),
        .rst_cause (cause_e),
        .wake_irq  (wake_irq)
    );

    assign rst_cause = cause_e;

endmodule

// File: rtl/redund_wdog_chk.sv
module redund_wdog_chk
    import redund_wdog_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               osc_tick,
    input logic               svc_valid,
    input logic [PCODE_W-1:0] svc_period,
    input logic [MCODE_W-1:0] svc_mode,
    input logic               rst_req,
    input logic [1:0]         rst_cause,
    input logic               wake_irq
);

    p_bad_period_r3: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !period_code_legal(svc_period)) |=> (rst_req && rst_cause == 2'b10));

    p_bad_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && period_code_legal(svc_period) && !mode_code_legal(svc_mode))
        |=> (rst_req && rst_cause == 2'b11));

    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!svc_valid && !osc_tick) |=> (!rst_req && !wake_irq));

    p_cause_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> (rst_cause == 2'b00));

    p_excl_pulses_r12: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && wake_irq));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);

endmodule

bind redund_wdog redund_wdog_chk u_chk (.*);

// File: tb/redund_wdog_bench.sv
`timescale 1ns/1ps
module redund_wdog_bench;

    localparam int BASE = 2;
    localparam int SIDX = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       svc_valid = 1'b0;
    logic [3:0] svc_period = 4'h0;
    logic [2:0] svc_mode = 3'b000;
    logic       rst_req;
    logic [1:0] rst_cause;
    logic       wake_irq;

    always #4 clk = ~clk;

    redund_wdog #(.BASE_LOG2(BASE), .START_IDX(SIDX)) u_redund_wdog (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .svc_valid(svc_valid),
        .svc_period(svc_period), .svc_mode(svc_mode),
        .rst_req(rst_req), .rst_cause(rst_cause), .wake_irq(wake_irq)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_beh;    // 0 start-up, 1 window, 2 time-out, 3 off
    int m_cnt;
    int m_per;
    bit m_sent;
    bit e_rst;
    int e_cause;
    bit e_irq;
    int legal_q[$];

    function automatic int code_rank(input int c);
        foreach (legal_q[i]) if (legal_q[i] == c) return i;
        return -1;
    endfunction

    function automatic int beh_of(input int mc);
        case (mc)
            1: return 0;
            2: return 1;
            3, 4: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic m_restart();
        m_beh = 0; m_cnt = 0; m_per = 1 << (SIDX + BASE); m_sent = 0;
    endtask

    task automatic m_eval(input bit sv, input int pc, input int mc, input bit tk);
        e_rst = 0; e_cause = 0; e_irq = 0;
        if (sv) begin
            if (code_rank(pc) < 0) begin e_rst = 1; e_cause = 2; m_restart(); end
            else if (mc == 0 || mc == 7) begin e_rst = 1; e_cause = 3; m_restart(); end
            else if (m_beh == 1 && m_cnt < m_per / 2) begin e_rst = 1; e_cause = 0; m_restart(); end
            else begin
                m_beh = beh_of(mc); m_per = 1 << (code_rank(pc) + BASE);
                m_cnt = 0; m_sent = 0;
            end
        end else if (tk && m_beh != 3) begin
            if (m_cnt == m_per - 1) begin
                if (m_beh == 2 && !m_sent) begin e_irq = 1; m_sent = 1; m_cnt = 0; end
                else begin e_rst = 1; e_cause = 1; m_restart(); end
            end else m_cnt++;
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (rst_req !== e_rst || rst_cause !== 2'(e_cause) || wake_irq !== e_irq) begin
            fails++;
            $display("FAIL %s: rst_req/cause/irq got %b/%b/%b expected %b/%b/%b",
                     tag, rst_req, rst_cause, wake_irq, e_rst, 2'(e_cause), e_irq);
        end
    endtask

    // drive at a negedge, compare at the following negedge
    task automatic step(input bit sv, input int pc, input int mc, input bit tk, input string tag);
        svc_valid = sv; svc_period = 4'(pc); svc_mode = 3'(mc); osc_tick = tk;
        m_eval(sv, pc, mc, tk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, tag);
    endtask

    task automatic svc(input int pc, input int mc, input string tag);
        step(1, pc, mc, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got running expected finished");
        finish_run();
    end

    initial begin
        for (int v = 0; v < 16; v++)
            if ($countones(4'(v)) == 1 || $countones(4'(v)) == 2) legal_q.push_back(v);
        m_restart(); e_rst = 0; e_cause = 0; e_irq = 0;
        repeat (3) @(negedge clk);
        compare("R12 reset state");
        rst = 1'b0;

        // R1 / R11: start-up period of 32 ticks expires, twice
        ticks(32, "R1 start-up overflow");
        ticks(32, "R11 start-up after request");

        // R13: start-up service at once, never early
        svc(4'h1, 1, "R13 start-up immediate service");
        ticks(2, "R13 ticks");
        // R5/R6: window, period 4, early service
        svc(4'h1, 2, "R5 enter window");
        ticks(1, "R6 ticks");
        svc(4'h1, 2, "R6 early service");
        // R7: late-half service accepted then expiry
        svc(4'h1, 2, "R13 start-up service");
        ticks(2, "R7 reach half");
        svc(4'h1, 2, "R7 service at half");
        ticks(3, "R7 reach last");
        svc(4'h2, 2, "R7 service at last tick");
        ticks(8, "R7 window overflow");

        // R3 / R4 illegal codes
        svc(4'h7, 2, "R3 three bits set");
        svc(4'h0, 2, "R3 zero code");
        svc(4'hF, 7, "R3 precedence over bad mode");
        svc(4'h3, 0, "R4 mode 000");
        svc(4'h3, 7, "R4 mode 111");

        // R10: tick coinciding with service is not counted
        svc(4'h1, 2, "R10 window");
        ticks(2, "R10 ticks");
        step(1, 4'h1, 2, 1, "R10 service with tick");
        step(1, 4'h1, 2, 0, "R10 immediate early");
        // R8: time-out double expiry, modes 011 and 100
        svc(4'h2, 3, "R8 enter time-out");
        ticks(8, "R8 first expiry irq");
        ticks(8, "R8 second expiry reset");
        svc(4'h1, 4, "R5 time-out alt code");
        ticks(1, "R13 ticks");
        svc(4'h1, 4, "R13 time-out early accepted");
        ticks(4, "R8 irq");
        svc(4'h1, 4, "R8 service clears");
        ticks(4, "R8 irq again");
        ticks(4, "R8 reset");

        // R9: off behaviour ignores ticks
        svc(4'hC, 5, "R9 enter off");
        ticks(3000, "R9 off quiet");
        svc(4'h1, 6, "R9 alt off code");
        ticks(50, "R9 off quiet 2");
        svc(4'h1, 2, "R9 leave off");

        // R2: every legal code to overflow in window, gapped ticks
        foreach (legal_q[k]) begin
            svc(legal_q[k], 1, "R2 start-up load");
            svc(legal_q[k], 2, "R2 window load");
            for (int t = 0; t < (1 << (k + BASE)) + 2; t++)
                step(0, 0, 0, (t % 3) != 1, "R2 period sweep");
            ticks((1 << (k + BASE)) - 1, "R2 finish period");
            ticks(40, "R11 back in start-up");
        end

        step(0, 0, 0, 0, "R12 idle");
        finish_run();
    end

endmodule